// File: doc/BRIEF.md
# Tagged Floating-Point Register Stack

This block holds eight 80-bit extended-precision registers, organised as a circular stack. A 3-bit top pointer locates the stack, and each physical entry has an empty tag. A relative index i names ST(i), which lives at physical slot (top + i) mod 8. The block carries out the register-level half of floating-point load, store and conditional-move instructions. Memory access and format conversion are done upstream, so a value to be loaded arrives already in 80-bit form, together with a flag that says whether its conversion was invalid.

Every operation checks the empty tags it depends on. A push into an occupied slot is a stack overflow. Reading an empty register is a stack underflow. When an underflow or invalid conversion occurs, the invalid-operation mask input decides the outcome. If the mask is set, the default NaN is written in place of the missing value. If it is clear, the register update is suppressed.

Single-cycle operations are accepted and completed in state IDLE. A conditional move takes transition ACCEPT_CMOV from IDLE to CMOV_WAIT, where it holds `busy` high. Its fourth clock edge takes transition FINISH_CMOV back to IDLE and writes the result. The exception flags and C1 always describe the most recent completed operation.

Top module: `fp_regstack`

## Requirements
- R1: After reset the top pointer is 0, all eight entries are empty (`st0_empty`=1), `busy` is 0 and the overflow, underflow, invalid and C1 outputs are 0.
- R2: Op code 1 (load value) pushes `op_data`. The top pointer decrements modulo 8 and ST(0) becomes that value and is marked full. It is visible after the accepting clock edge.
- R3: Any push (op codes 1 and 2) whose target slot ST(-1) is full sets the overflow flag and C1 to 1. The top pointer, the tags and the register contents are left unchanged.
- R4: Every completed load, store or conditional move (op codes 1 to 5) rewrites all four status outputs. C1 is 1 only on overflow. The overflow, underflow and invalid flags are each 0 unless that operation raised them.
- R5: Op code 2 (load register) pushes a copy of ST(`op_idx`). If that entry is empty, underflow is set. With the mask at 1 the default NaN is pushed; with the mask at 0 nothing is pushed. The default NaN is sign 1, exponent 7FFF, fraction C000_0000_0000_0000, i.e. 80'hFFFF_C000_0000_0000_0000.
- R6: Op code 1 with `conv_invalid`=1 sets the invalid flag. It pushes `op_data` only when the mask is 1; with the mask at 0 the stack is unchanged.
- R7: Op code 3 (store) copies ST(0) into ST(`op_idx`) and marks it full. If ST(0) is empty, underflow is set, and the default NaN is written to ST(`op_idx`) only when the mask is 1.
- R8: Op code 4 (store and pop) behaves as op code 3 and then pops: it marks the old top empty and increments the pointer. An unmasked underflow does not pop.
- R9: Op code 5 (conditional move) sets underflow if ST(0) or ST(`op_idx`) is empty. With the mask at 1 ST(0) becomes the default NaN; with the mask at 0 ST(0) is unchanged.
- R10: Conditional-move condition codes on `cond_sel` are: 0 below (C flag), 1 equal (Z), 2 below-or-equal (C or Z), 3 unordered (P). Codes 4 to 7 are the negations of codes 0 to 3. When both operands are full, ST(i) is copied into ST(0) only if the condition holds.
- R11: A conditional move takes 4 clocks. After the accepting edge `busy` is 1 for exactly 3 cycles, and the result appears after the fourth edge. Condition flags, index and mask are captured at acceptance. Operations offered while `busy` is 1 are ignored.
- R12: Op codes 0, 6 and 7 change neither the stack nor any status output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation offered this cycle |
| op_code | input | 3 | Operation select (see R2 to R12) |
| op_idx | input | 3 | Relative register index i |
| op_data | input | 80 | Converted value for a load |
| conv_invalid | input | 1 | Conversion of `op_data` raised invalid |
| invalid_mask | input | 1 | 1 = invalid operation masked |
| cond_sel | input | 3 | Conditional-move condition code |
| flag_c | input | 1 | Below flag |
| flag_z | input | 1 | Equal flag |
| flag_p | input | 1 | Unordered flag |
| busy | output | 1 | Conditional move in progress |
| st0_data | output | 80 | Contents of ST(0) |
| st0_empty | output | 1 | ST(0) tag is empty |
| top_ptr | output | 3 | Current top pointer |
| ovf_flag | output | 1 | Last operation overflowed the stack |
| unf_flag | output | 1 | Last operation underflowed the stack |
| inv_flag | output | 1 | Last load had an invalid conversion |
| c1_flag | output | 1 | Condition bit C1 |

## Verification
The bound checker watches, on every cycle, that:
- a push lowers the top pointer by one and a pop raises it by one;
- a newly raised overflow leaves the pointer in place;
- C1 never stands without overflow;
- overflow and underflow never coincide;
- the pointer is frozen while `busy` is high;
- `busy` never runs longer than three cycles.

Some behaviours are visible only through the bench's sequences: data values actually moving between relative slots, default-NaN substitution in the masked cases, and suppression in the unmasked ones. The same goes for all eight condition codes, the capture of flags at acceptance, and operations being ignored while busy.

// File: rtl/fpstk_pkg.sv
package fpstk_pkg;

    typedef enum logic [2:0] {
        OP_NOP  = 3'd0,
        OP_LDV  = 3'd1,
        OP_LDR  = 3'd2,
        OP_ST   = 3'd3,
        OP_STP  = 3'd4,
        OP_CMOV = 3'd5
    } op_e;

    typedef enum logic {
        S_IDLE,
        S_CMOV_WAIT
    } state_e;

endpackage

// File: rtl/fpstk_regfile.sv
module fpstk_regfile #(
    parameter int DEPTH = 8,
    parameter int W     = 80,
    localparam int PW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] rd_rel,
    output logic [W-1:0]  rd_data,
    output logic          rd_empty,
    output logic [W-1:0]  top_data,
    output logic          top_empty,
    output logic          below_empty,
    input  logic          wr_en,
    input  logic [PW-1:0] wr_rel,
    input  logic [W-1:0]  wr_data,
    input  logic          push_en,
    input  logic          pop_en,
    output logic [PW-1:0] top_ptr
);

    logic [W-1:0]     mem [DEPTH];
    logic [DEPTH-1:0] empty_tag;
    logic [PW-1:0]    wr_phys, rd_phys, below_phys;

    assign wr_phys    = top_ptr + wr_rel;
    assign rd_phys    = top_ptr + rd_rel;
    assign below_phys = top_ptr - PW'(1);

    assign rd_data     = mem[rd_phys];
    assign rd_empty    = empty_tag[rd_phys];
    assign top_data    = mem[top_ptr];
    assign top_empty   = empty_tag[top_ptr];
    assign below_empty = empty_tag[below_phys];

    // data storage carries no reset: tags qualify every read
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_phys] <= wr_data;
    end

    // a pop in the same cycle as a write to the top wins on the tag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            empty_tag <= '1;
            top_ptr   <= '0;
        end else begin
            if (wr_en) empty_tag[wr_phys] <= 1'b0;
            if (pop_en) begin
                empty_tag[top_ptr] <= 1'b1;
                top_ptr            <= top_ptr + PW'(1);
            end else if (push_en) begin
                top_ptr <= top_ptr - PW'(1);
            end
        end
    end

endmodule

// File: rtl/fpstk_cond.sv
module fpstk_cond (
    input  logic [2:0] sel,
    input  logic       cf,
    input  logic       zf,
    input  logic       pf,
    output logic       hit
);

    logic base;

    always_comb begin
        unique case (sel[1:0])
            2'd0:    base = cf;
            2'd1:    base = zf;
            2'd2:    base = cf | zf;
            default: base = pf;
        endcase
        hit = sel[2] ? ~base : base;
    end

endmodule

// File: rtl/fp_regstack.sv
module fp_regstack
    import fpstk_pkg::*;
#(
    parameter int DEPTH       = 8,
    parameter int W           = 80,
    parameter int CMOV_CYCLES = 4,
    localparam int PW         = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          op_valid,
    input  logic [2:0]    op_code,
    input  logic [PW-1:0] op_idx,
    input  logic [W-1:0]  op_data,
    input  logic          conv_invalid,
    input  logic          invalid_mask,
    input  logic [2:0]    cond_sel,
    input  logic          flag_c,
    input  logic          flag_z,
    input  logic          flag_p,
    output logic          busy,
    output logic [W-1:0]  st0_data,
    output logic          st0_empty,
    output logic [PW-1:0] top_ptr,
    output logic          ovf_flag,
    output logic          unf_flag,
    output logic          inv_flag,
    output logic          c1_flag
);

    localparam int CW = $clog2(CMOV_CYCLES);
    localparam logic [CW-1:0] CNT_LAST = CW'(CMOV_CYCLES - 2);
    localparam logic [W-1:0]  DEF_NAN  = {1'b1, {15{1'b1}}, 2'b11, {(W-18){1'b0}}};

    state_e        state, state_nx;
    logic [CW-1:0] cnt;
    logic [PW-1:0] l_idx;
    logic [2:0]    l_cond;
    logic          l_cf, l_zf, l_pf, l_mask;

    logic [PW-1:0] rd_rel, wr_rel;
    logic [W-1:0]  rd_data, wr_data;
    logic          rd_empty, below_empty;
    logic          wr_en, push_en, pop_en, upd;
    logic          n_ovf, n_unf, n_inv, n_c1;
    logic          cond_hit, accept_cmov, finish_cmov;

    assign busy        = (state == S_CMOV_WAIT);
    assign accept_cmov = (state == S_IDLE) && op_valid && (op_code == OP_CMOV);
    assign finish_cmov = (state == S_CMOV_WAIT) && (cnt == CNT_LAST);
    assign rd_rel      = (state == S_IDLE) ? op_idx : l_idx;

    fpstk_regfile #(.DEPTH(DEPTH), .W(W)) u_rf (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_rel     (rd_rel),
        .rd_data    (rd_data),
        .rd_empty   (rd_empty),
        .top_data   (st0_data),
        .top_empty  (st0_empty),
        .below_empty(below_empty),
        .wr_en      (wr_en),
        .wr_rel     (wr_rel),
        .wr_data    (wr_data),
        .push_en    (push_en),
        .pop_en     (pop_en),
        .top_ptr    (top_ptr)
    );

    fpstk_cond u_cond (
        .sel(l_cond),
        .cf (l_cf),
        .zf (l_zf),
        .pf (l_pf),
        .hit(cond_hit)
    );

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:      if (accept_cmov) state_nx = S_CMOV_WAIT;
            S_CMOV_WAIT: if (finish_cmov) state_nx = S_IDLE;
        endcase
    end

    // state register, wait counter and captured conditional-move operands
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            cnt    <= '0;
            l_idx  <= '0;
            l_cond <= '0;
            l_cf   <= 1'b0;
            l_zf   <= 1'b0;
            l_pf   <= 1'b0;
            l_mask <= 1'b0;
        end else begin
            state <= state_nx;
            if (accept_cmov) begin
                cnt    <= '0;
                l_idx  <= op_idx;
                l_cond <= cond_sel;
                l_cf   <= flag_c;
                l_zf   <= flag_z;
                l_pf   <= flag_p;
                l_mask <= invalid_mask;
            end else if (busy) begin
                cnt <= cnt + CW'(1);
            end
        end
    end

    // operation decode: register commands and next status
    always_comb begin
        wr_en   = 1'b0;
        wr_rel  = '0;
        wr_data = rd_data;
        push_en = 1'b0;
        pop_en  = 1'b0;
        upd     = 1'b0;
        n_ovf   = 1'b0;
        n_unf   = 1'b0;
        n_inv   = 1'b0;
        n_c1    = 1'b0;
        unique case (state)
            S_IDLE: begin
                if (op_valid) begin
                    case (op_code)
                        OP_LDV, OP_LDR: begin
                            upd = 1'b1;
                            if (!below_empty) begin
                                n_ovf = 1'b1;
                                n_c1  = 1'b1;
                            end else if (op_code == OP_LDV) begin
                                n_inv = conv_invalid;
                                if (!conv_invalid || invalid_mask) begin
                                    push_en = 1'b1;
                                    wr_en   = 1'b1;
                                    wr_rel  = '1;
                                    wr_data = op_data;
                                end
                            end else if (rd_empty) begin
                                n_unf = 1'b1;
                                if (invalid_mask) begin
                                    push_en = 1'b1;
                                    wr_en   = 1'b1;
                                    wr_rel  = '1;
                                    wr_data = DEF_NAN;
                                end
                            end else begin
                                push_en = 1'b1;
                                wr_en   = 1'b1;
                                wr_rel  = '1;
                                wr_data = rd_data;
                            end
                        end
                        OP_ST, OP_STP: begin
                            upd    = 1'b1;
                            wr_rel = op_idx;
                            if (st0_empty) begin
                                n_unf = 1'b1;
                                if (invalid_mask) begin
                                    wr_en   = 1'b1;
                                    wr_data = DEF_NAN;
                                    pop_en  = (op_code == OP_STP);
                                end
                            end else begin
                                wr_en   = 1'b1;
                                wr_data = st0_data;
                                pop_en  = (op_code == OP_STP);
                            end
                        end
                        default: ;
                    endcase
                end
            end
            S_CMOV_WAIT: begin
                if (finish_cmov) begin
                    upd = 1'b1;
                    if (st0_empty || rd_empty) begin
                        n_unf = 1'b1;
                        if (l_mask) begin
                            wr_en   = 1'b1;
                            wr_data = DEF_NAN;
                        end
                    end else if (cond_hit) begin
                        wr_en   = 1'b1;
                        wr_data = rd_data;
                    end
                end
            end
        endcase
    end

    // status outputs describe the last completed operation
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovf_flag <= 1'b0;
            unf_flag <= 1'b0;
            inv_flag <= 1'b0;
            c1_flag  <= 1'b0;
        end else if (upd) begin
            ovf_flag <= n_ovf;
            unf_flag <= n_unf;
            inv_flag <= n_inv;
            c1_flag  <= n_c1;
        end
    end

endmodule

// File: rtl/fp_regstack_chk.sv
module fp_regstack_chk #(
    parameter int PW          = 3,
    parameter int CMOV_CYCLES = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic [PW-1:0] top_ptr,
    input logic          ovf_flag,
    input logic          unf_flag,
    input logic          c1_flag,
    input logic          push_en,
    input logic          pop_en
);

    localparam int RW = $clog2(CMOV_CYCLES) + 1;
    logic [RW-1:0] busy_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    busy_run <= '0;
        else if (busy) busy_run <= busy_run + RW'(1);
        else           busy_run <= '0;
    end

    assert_push_dec_R2: assert property (@(posedge clk) disable iff (!rst_n)
        push_en |=> top_ptr == $past(top_ptr) - PW'(1));

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flag) |-> $stable(top_ptr));

    assert_c1_only_ovf_R4: assert property (@(posedge clk) disable iff (!rst_n)
        c1_flag |-> ovf_flag);

    assert_pop_inc_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pop_en |=> top_ptr == $past(top_ptr) + PW'(1));

    assert_flag_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(ovf_flag && unf_flag));

    assert_busy_len_R11: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> busy_run < RW'(CMOV_CYCLES - 1));

    assert_busy_top_R11: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(top_ptr));

endmodule

bind fp_regstack fp_regstack_chk #(.PW(PW), .CMOV_CYCLES(CMOV_CYCLES)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy    (busy),
    .top_ptr (top_ptr),
    .ovf_flag(ovf_flag),
    .unf_flag(unf_flag),
    .c1_flag (c1_flag),
    .push_en (push_en),
    .pop_en  (pop_en)
);

// File: tb/sim_fp_regstack.sv
module sim_fp_regstack;

    localparam logic [79:0] NAN = 80'hFFFF_C000_0000_0000_0000;

    typedef struct packed {
        logic [2:0]  op;
        logic [2:0]  idx;
        logic        mask;
        logic        cinv;
        logic [15:0] dat;
        logic [2:0]  top;
        logic        st0e;
        logic [15:0] st0;
        logic        ovf, unf, inv, c1;
    } vec_t;

    localparam int NV = 25;
    localparam vec_t VEC [NV] = '{
        '{3'd1,3'd0,1'b0,1'b0,16'h0011, 3'd7,1'b0,16'h0011, 1'b0,1'b0,1'b0,1'b0}, // R2
        '{3'd1,3'd0,1'b0,1'b0,16'h0022, 3'd6,1'b0,16'h0022, 1'b0,1'b0,1'b0,1'b0}, // R2
        '{3'd2,3'd1,1'b0,1'b0,16'h0000, 3'd5,1'b0,16'h0011, 1'b0,1'b0,1'b0,1'b0}, // R5 copy
        '{3'd3,3'd1,1'b0,1'b0,16'h0000, 3'd5,1'b0,16'h0011, 1'b0,1'b0,1'b0,1'b0}, // R7 store
        '{3'd4,3'd0,1'b0,1'b0,16'h0000, 3'd6,1'b0,16'h0011, 1'b0,1'b0,1'b0,1'b0}, // R8 pop shows stored
        '{3'd2,3'd5,1'b0,1'b0,16'h0000, 3'd6,1'b0,16'h0011, 1'b0,1'b1,1'b0,1'b0}, // R5 unmasked
        '{3'd1,3'd0,1'b0,1'b1,16'h0033, 3'd6,1'b0,16'h0011, 1'b0,1'b0,1'b1,1'b0}, // R6 unmasked
        '{3'd1,3'd0,1'b1,1'b1,16'h0033, 3'd5,1'b0,16'h0033, 1'b0,1'b0,1'b1,1'b0}, // R6 masked
        '{3'd4,3'd0,1'b0,1'b0,16'h0000, 3'd6,1'b0,16'h0011, 1'b0,1'b0,1'b0,1'b0}, // R8
        '{3'd4,3'd0,1'b0,1'b0,16'h0000, 3'd7,1'b0,16'h0011, 1'b0,1'b0,1'b0,1'b0}, // R8
        '{3'd4,3'd0,1'b0,1'b0,16'h0000, 3'd0,1'b1,16'h0000, 1'b0,1'b0,1'b0,1'b0}, // R8 to empty
        '{3'd3,3'd3,1'b0,1'b0,16'h0000, 3'd0,1'b1,16'h0000, 1'b0,1'b1,1'b0,1'b0}, // R7 underflow
        '{3'd4,3'd0,1'b0,1'b0,16'h0000, 3'd0,1'b1,16'h0000, 1'b0,1'b1,1'b0,1'b0}, // R8 no pop
        '{3'd1,3'd0,1'b0,1'b0,16'h0040, 3'd7,1'b0,16'h0040, 1'b0,1'b0,1'b0,1'b0},
        '{3'd1,3'd0,1'b0,1'b0,16'h0041, 3'd6,1'b0,16'h0041, 1'b0,1'b0,1'b0,1'b0},
        '{3'd1,3'd0,1'b0,1'b0,16'h0042, 3'd5,1'b0,16'h0042, 1'b0,1'b0,1'b0,1'b0},
        '{3'd1,3'd0,1'b0,1'b0,16'h0043, 3'd4,1'b0,16'h0043, 1'b0,1'b0,1'b0,1'b0},
        '{3'd1,3'd0,1'b0,1'b0,16'h0044, 3'd3,1'b0,16'h0044, 1'b0,1'b0,1'b0,1'b0},
        '{3'd1,3'd0,1'b0,1'b0,16'h0045, 3'd2,1'b0,16'h0045, 1'b0,1'b0,1'b0,1'b0},
        '{3'd1,3'd0,1'b0,1'b0,16'h0046, 3'd1,1'b0,16'h0046, 1'b0,1'b0,1'b0,1'b0},
        '{3'd1,3'd0,1'b0,1'b0,16'h0047, 3'd0,1'b0,16'h0047, 1'b0,1'b0,1'b0,1'b0},
        '{3'd1,3'd0,1'b0,1'b0,16'h0050, 3'd0,1'b0,16'h0047, 1'b1,1'b0,1'b0,1'b1}, // R3
        '{3'd2,3'd2,1'b0,1'b0,16'h0000, 3'd0,1'b0,16'h0047, 1'b1,1'b0,1'b0,1'b1}, // R3
        '{3'd6,3'd1,1'b0,1'b0,16'h0099, 3'd0,1'b0,16'h0047, 1'b1,1'b0,1'b0,1'b1}, // R12
        '{3'd1,3'd0,1'b0,1'b1,16'h0055, 3'd0,1'b0,16'h0047, 1'b1,1'b0,1'b0,1'b1}  // R3 before R6
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        op_valid, conv_invalid, invalid_mask;
    logic [2:0]  op_code, op_idx, cond_sel;
    logic [79:0] op_data;
    logic        flag_c, flag_z, flag_p;
    logic        busy, st0_empty, ovf_flag, unf_flag, inv_flag, c1_flag;
    logic [79:0] st0_data;
    logic [2:0]  top_ptr;

    int checks = 0;
    int bad    = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    fp_regstack u0 (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .op_idx(op_idx), .op_data(op_data), .conv_invalid(conv_invalid),
        .invalid_mask(invalid_mask), .cond_sel(cond_sel), .flag_c(flag_c),
        .flag_z(flag_z), .flag_p(flag_p), .busy(busy), .st0_data(st0_data),
        .st0_empty(st0_empty), .top_ptr(top_ptr), .ovf_flag(ovf_flag),
        .unf_flag(unf_flag), .inv_flag(inv_flag), .c1_flag(c1_flag)
    );

    task automatic chk(input string req, input string what, input logic [79:0] act, input logic [79:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic string req_of(input vec_t v);
        if (v.ovf)                 return "R3";
        if (v.op == 3'd6)          return "R12";
        if (v.inv)                 return "R6";
        if (v.op == 3'd2)          return "R5";
        if (v.op == 3'd3)          return "R7";
        if (v.op == 3'd4)          return "R8";
        return "R2";
    endfunction

    task automatic do_op(input logic [2:0] op, input logic [2:0] idx, input logic [79:0] d,
                         input logic m, input logic ci);
        @(negedge clk);
        op_valid = 1'b1; op_code = op; op_idx = idx; op_data = d;
        invalid_mask = m; conv_invalid = ci;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    // conditional move; a push is offered and condition flags flipped while busy
    task automatic do_cmov(input logic [2:0] cs, input logic [2:0] idx,
                           input logic c, input logic z, input logic p, input logic m);
        int n;
        logic [2:0] top_before;
        top_before = top_ptr;
        @(negedge clk);
        op_valid = 1'b1; op_code = 3'd5; op_idx = idx; cond_sel = cs;
        flag_c = c; flag_z = z; flag_p = p; invalid_mask = m; conv_invalid = 1'b0;
        @(negedge clk);
        op_code = 3'd1; op_data = 80'h1234; op_idx = 3'd0;
        flag_c = ~c; flag_z = ~z; flag_p = ~p; invalid_mask = ~m;
        n = 0;
        while (busy && n < 10) begin
            n++;
            @(negedge clk);
        end
        op_valid = 1'b0;
        chk("R11", "busy cycles", 80'(n), 80'd3);
        chk("R11", "top kept while busy", 80'(top_ptr), 80'(top_before));
    endtask

    task automatic chk_flags(input string req, input logic [3:0] exp);
        chk(req, "ovf,unf,inv,c1", 80'({ovf_flag, unf_flag, inv_flag, c1_flag}), 80'(exp));
    endtask

    task automatic finish_up;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            finish_up();
        end
    end

    initial begin
        rst_n = 1'b0; op_valid = 1'b0; op_code = 3'd0; op_idx = 3'd0; op_data = '0;
        conv_invalid = 1'b0; invalid_mask = 1'b0; cond_sel = 3'd0;
        flag_c = 1'b0; flag_z = 1'b0; flag_p = 1'b0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", "top", 80'(top_ptr), 80'd0);
        chk("R1", "st0_empty", 80'(st0_empty), 80'd1);
        chk("R1", "busy", 80'(busy), 80'd0);
        chk_flags("R1", 4'b0000);
        rst_n = 1'b1;

        for (int k = 0; k < NV; k++) begin
            do_op(VEC[k].op, VEC[k].idx, {64'd0, VEC[k].dat}, VEC[k].mask, VEC[k].cinv);
            chk(req_of(VEC[k]), $sformatf("vec %0d top", k), 80'(top_ptr), 80'(VEC[k].top));
            chk(req_of(VEC[k]), $sformatf("vec %0d st0_empty", k), 80'(st0_empty), 80'(VEC[k].st0e));
            if (!VEC[k].st0e)
                chk(req_of(VEC[k]), $sformatf("vec %0d st0", k), st0_data, {64'd0, VEC[k].st0});
            chk_flags("R4", {VEC[k].ovf, VEC[k].unf, VEC[k].inv, VEC[k].c1});
        end

        // full stack: ST(i) holds 0x47 - i; R10 condition codes
        do_cmov(3'd1, 3'd1, 1'b0, 1'b1, 1'b0, 1'b0);
        chk("R10", "E taken", st0_data, 80'h46);
        chk_flags("R4", 4'b0000);
        do_cmov(3'd1, 3'd2, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R10", "E not taken", st0_data, 80'h46);
        do_cmov(3'd5, 3'd2, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R10", "NE taken", st0_data, 80'h45);
        do_cmov(3'd2, 3'd3, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R10", "BE not taken", st0_data, 80'h45);
        do_cmov(3'd6, 3'd3, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R10", "NBE taken", st0_data, 80'h44);
        do_cmov(3'd3, 3'd4, 1'b0, 1'b0, 1'b1, 1'b0);
        chk("R10", "U taken", st0_data, 80'h43);
        do_cmov(3'd7, 3'd1, 1'b0, 1'b0, 1'b1, 1'b0);
        chk("R10", "NU not taken", st0_data, 80'h43);
        do_cmov(3'd0, 3'd1, 1'b1, 1'b0, 1'b0, 1'b0);
        chk("R10", "B taken", st0_data, 80'h46);
        do_cmov(3'd4, 3'd2, 1'b1, 1'b0, 1'b0, 1'b0);
        chk("R10", "NB not taken", st0_data, 80'h46);

        for (int k = 0; k < 8; k++) do_op(3'd4, 3'd0, '0, 1'b0, 1'b0);
        chk("R8", "emptied top", 80'(top_ptr), 80'd0);
        chk("R8", "emptied st0", 80'(st0_empty), 80'd1);

        do_op(3'd1, 3'd0, 80'h77, 1'b0, 1'b0);
        do_cmov(3'd1, 3'd3, 1'b0, 1'b1, 1'b0, 1'b0);
        chk("R9", "unmasked st0 kept", st0_data, 80'h77);
        chk_flags("R9", 4'b0100);
        do_cmov(3'd1, 3'd3, 1'b0, 1'b1, 1'b0, 1'b1);
        chk("R9", "masked st0 NaN", st0_data, NAN);
        chk_flags("R9", 4'b0100);

        do_op(3'd2, 3'd4, '0, 1'b1, 1'b0);
        chk("R5", "masked push top", 80'(top_ptr), 80'd6);
        chk("R5", "masked push NaN", st0_data, NAN);
        chk_flags("R5", 4'b0100);

        do_op(3'd4, 3'd0, '0, 1'b0, 1'b0);
        do_op(3'd4, 3'd0, '0, 1'b0, 1'b0);
        do_op(3'd3, 3'd3, '0, 1'b1, 1'b0);
        chk_flags("R7", 4'b0100);
        chk("R7", "masked store keeps top", 80'(top_ptr), 80'd0);
        do_op(3'd2, 3'd3, '0, 1'b0, 1'b0);
        chk("R7", "masked store wrote NaN", st0_data, NAN);
        chk_flags("R7", 4'b0000);
        chk("R7", "top after reload", 80'(top_ptr), 80'd7);

        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1", "top after reset", 80'(top_ptr), 80'd0);
        chk("R1", "st0_empty after reset", 80'(st0_empty), 80'd1);
        chk_flags("R1", 4'b0000);

        done = 1;
        finish_up();
    end

endmodule